// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the bus-facing controller of a small byte-wide storage array that answers as a slave on a two-wire serial bus. It oversamples the clock and data lines with the system clock, finds start and stop conditions, and decodes a select byte followed by a two-byte memory address. It then carries out single-byte and multi-byte writes, reads at the current address, reads at a freshly set address and reads that run across several bytes.

Writes collect data in page latches and commit them only when the master closes the transfer with a stop on a byte boundary. The commit starts a self-timed write cycle during which the slave stays off the bus, so a master learns that the cycle has ended by repeating the select byte until it is acknowledged. A write-lock input lets the slave accept select and address bytes while it refuses every data byte. The data line is open-drain: the block only ever pulls it low or lets it go.

Top module: `i2c_mem_slave`

## Requirements
- R1: The select byte arrives MSB first as {4'b1010, three chip bits, R/W}, with R/W=1 meaning read. The slave acknowledges it only when the type nibble is 1010 and the chip bits equal `chip_sel_i`; on a mismatch it leaves SDA released and ignores the bus until the next start.
- R2: After a select byte with R/W=0, two address bytes follow, high byte first. Both are acknowledged, and the low ADDR_W bits of the 16-bit value load the address counter.
- R3: Each acknowledged data byte is held in a page latch. The latched bytes are written to the array when a stop arrives on a byte boundary.
- R4: During a write only the low PAGE_W bits of the address counter advance after each data byte, so the writes wrap inside the page and the upper bits stay fixed.
- R5: While `wr_lock_i` is high, select and address bytes are still acknowledged, every data byte gets no acknowledge, and the array is left unchanged with no write cycle started.
- R6: A committed write starts a write cycle of WR_CYCLES clocks. During this cycle the slave ignores the bus and does not acknowledge its select byte; when the cycle ends it answers again.
- R7: A read that sends only the select byte with R/W=1 returns the byte at the address counter, and the counter then moves to the next address.
- R8: A dummy write of the address, then a repeated start and a read select, returns bytes from that address. A master acknowledge (SDA low in the 9th slot) continues at the next array address. A missing acknowledge ends the transfer with SDA released.
- R9: The slave only pulls SDA low or releases it, changes it only while SCL is low, and keeps it released from reset and while idle.
- R10: After reset every array byte reads 0xFF.
- R11: A start or stop in the middle of a byte aborts the operation. A write aborted this way commits nothing and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| chip_sel_i | input | 3 | Chip bits that the select byte must match |
| wr_lock_i | input | 1 | High refuses data bytes of writes |
| sda_pull_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The bench builds the block with ADDR_W=8, PAGE_W=3 and WR_CYCLES=600. An eight-byte page lets a five-byte page write cross the page end, and a sequential read then shows the wrapped layout. The short write cycle lets one poll, issued right after a stop, land inside the busy window, while the following transfers run after it has ended. Address bytes with a non-zero high byte show that only the low address bits are kept.

// File: rtl/i2cm_pkg.sv
// Shared types for the serial memory slave.
// Assumes: one protocol engine per instance; the encodings are local to the block.
package i2cm_pkg;
    // Protocol phases of the slave engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } bus_st_t;

    // Type nibble that selects the storage array
    localparam logic [3:0] MEM_TYPE_ID = 4'b1010;
endpackage

// File: rtl/i2cm_line_sync.sv
// Brings SCL and SDA into the clock domain and flags edges and bus conditions.
// Assumes: the bus idles high and each line stays stable for several clocks.
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chains plus one delayed copy for edge finding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = !scl_d && scl_lvl;
    assign scl_fall  = scl_d && !scl_lvl;
    assign bus_start = scl_d && scl_lvl && sda_d && !sda_lvl;
    assign bus_stop  = scl_d && scl_lvl && !sda_d && sda_lvl;
endmodule

// File: rtl/i2cm_store.sv
// Storage array, page latches and self-timed write cycle timer.
// Assumes: commit is raised only while not busy; latch clears and commits are single pulses.
module i2cm_store #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 7,
    parameter int WR_CYCLES = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lat_we,
    input  logic [PAGE_W-1:0]        lat_idx,
    input  logic [7:0]               lat_data,
    input  logic                     lat_clr,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page_sel,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy,
    output logic                     has_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [7:0]       mem   [DEPTH];
    logic [7:0]       latch [PAGE];
    logic [PAGE-1:0]  lat_vld;
    logic [CNT_W-1:0] wcnt;

    // Array: erased on reset, loaded from valid latches on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (lat_vld[i]) mem[{page_sel, PAGE_W'(i)}] <= latch[i];
        end
    end

    // Latch data capture
    always_ff @(posedge clk) begin
        if (lat_we) latch[lat_idx] <= lat_data;
    end

    // Latch valid flags: set on capture, dropped on commit or abort
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_vld <= '0;
        else if (commit || lat_clr) lat_vld <= '0;
        else if (lat_we)           lat_vld[lat_idx] <= 1'b1;
    end

    // Write cycle timer
    always_ff @(posedge clk) begin
        if (!rst_n)           wcnt <= '0;
        else if (commit)      wcnt <= CNT_W'(WR_CYCLES);
        else if (wcnt != '0)  wcnt <= wcnt - CNT_W'(1);
    end

    assign rd_data  = mem[rd_addr];
    assign busy     = (wcnt != '0);
    assign has_data = |lat_vld;

    // R6: a commit is only requested while the array is free
    a_r6_commit_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);

    // R6: a commit always opens a write cycle
    a_r6_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);
endmodule

// File: rtl/i2c_mem_slave.sv
// Serial bus slave front end for a byte-addressed storage array.
// Decodes select and address bytes, runs writes through page latches and reads
// with address auto-increment, and drives SDA as open drain (sda_pull_o=1 pulls low).
// Assumes: SCL phases last several system clocks; ADDR_W <= 16 and PAGE_W < ADDR_W.
module i2c_mem_slave #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 7,
    parameter int WR_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    import i2cm_pkg::*;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic busy, has_data, commit, lat_we, lat_clr, sel_hit;
    logic [7:0] rd_data;

    bus_st_t           st;
    logic [3:0]        cnt;
    logic [7:0]        sh;
    logic [7:0]        ahi;
    logic [7:0]        tx;
    logic              mack;
    logic              pull;
    logic [ADDR_W-1:0] addr;

    i2cm_line_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    i2cm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat_we  (lat_we),
        .lat_idx (addr[PAGE_W-1:0]),
        .lat_data(sh),
        .lat_clr (lat_clr),
        .commit  (commit),
        .page_sel(addr[ADDR_W-1:PAGE_W]),
        .rd_addr (addr),
        .rd_data (rd_data),
        .busy    (busy),
        .has_data(has_data)
    );

    // Select byte decode against type nibble and chip pins
    assign sel_hit = (sh[7:4] == MEM_TYPE_ID) && (sh[3:1] == chip_sel_i);

    // Data byte capture strobe at the end of the 8th bit
    assign lat_we = (st == ST_WDAT) && scl_fall && (cnt == 4'd8) && !wr_lock_i
                    && !busy && !bus_start && !bus_stop;

    // Commit only on a stop at a byte boundary (the stop's own SCL rise counts one)
    assign commit  = bus_stop && !busy && (st == ST_WDAT) && (cnt <= 4'd1) && has_data;
    assign lat_clr = bus_start || bus_stop;

    // Protocol engine: bit counting, acknowledge, address and transmit shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            sh   <= '0;
            ahi  <= '0;
            tx   <= '0;
            mack <= 1'b0;
            pull <= 1'b0;
            addr <= '0;
        end else if (busy) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (bus_stop) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (bus_start) begin
            st   <= ST_SEL;
            cnt  <= '0;
            pull <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (scl_rise) begin
                if (cnt < 4'd8 && st != ST_RDAT) sh <= {sh[6:0], sda_lvl};
                if (cnt == 4'd8 && st == ST_RDAT) mack <= !sda_lvl;
                if (cnt != 4'd9) cnt <= cnt + 4'd1;
            end
            if (scl_fall) begin
                if (cnt == 4'd8) begin
                    case (st)
                        ST_SEL: begin
                            pull <= sel_hit;
                            if (!sel_hit) st <= ST_IDLE;
                        end
                        ST_AHI, ST_ALO: pull <= 1'b1;
                        ST_WDAT: begin
                            pull <= !wr_lock_i;
                            if (!wr_lock_i)
                                addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                        default: pull <= 1'b0;
                    endcase
                end else if (cnt == 4'd9) begin
                    cnt  <= '0;
                    pull <= 1'b0;
                    case (st)
                        ST_SEL: begin
                            if (sh[0]) begin
                                st   <= ST_RDAT;
                                tx   <= rd_data;
                                pull <= !rd_data[7];
                                addr <= addr + ADDR_W'(1);
                            end else begin
                                st <= ST_AHI;
                            end
                        end
                        ST_AHI: begin
                            ahi <= sh;
                            st  <= ST_ALO;
                        end
                        ST_ALO: begin
                            addr <= ADDR_W'({ahi, sh});
                            st   <= ST_WDAT;
                        end
                        ST_RDAT: begin
                            if (mack) begin
                                tx   <= rd_data;
                                pull <= !rd_data[7];
                                addr <= addr + ADDR_W'(1);
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end else if (st == ST_RDAT && cnt != 4'd0) begin
                    pull <= !tx[6];
                    tx   <= {tx[6:0], 1'b0};
                end
            end
        end
    end

    assign sda_pull_o = pull;

    // R6: nothing is driven onto the bus during the write cycle
    a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R9: the data line only moves while the clock line is low
    a_r9_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_lvl);

    // R4: capturing a data byte never moves the page bits of the counter
    a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/sim_i2c_mem_slave.sv
// Scoreboard bench: bus tasks push expected read bytes, a monitor compares them.
module sim_i2c_mem_slave;
    localparam int ADDR_W    = 8;
    localparam int PAGE_W    = 3;
    localparam int WR_CYCLES = 600;
    localparam int Q         = 5;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl   = 1'b1;
    logic       sda_m = 1'b1;
    logic       lock  = 1'b0;
    logic [2:0] cs    = 3'b101;
    logic       pull;
    logic       sda_bus;

    assign sda_bus = sda_m & ~pull;

    always #10 clk = ~clk;

    i2c_mem_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .chip_sel_i(cs),
        .wr_lock_i (lock),
        .sda_pull_o(pull)
    );

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] got_q[$];
    logic [7:0] model [256];
    logic [7:0] ptr = 8'h00;
    int total = 0;
    int bad   = 0;
    int r9_viol = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input bit mack);
        logic [7:0] v = '0;
        logic b;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            v = {v[6:0], b};
        end
        got_q.push_back(v);
        send_bit(!mack);
    endtask

    // Select, then both address bytes; acknowledges checked against R1 and R2
    task automatic addr_phase(input logic [15:0] a);
        bit ack;
        bus_start();
        send_byte({4'b1010, cs, 1'b0}, ack);
        check(ack, "R1", "write select ack", ack, 1);
        send_byte(a[15:8], ack);
        check(ack, "R2", "address high ack", ack, 1);
        send_byte(a[7:0], ack);
        check(ack, "R2", "address low ack", ack, 1);
    endtask

    // Random read of n bytes with master acknowledge on all but the last
    task automatic rd_expect(input logic [15:0] a, input int n, input string tag);
        bit ack;
        logic [7:0] base = a[7:0];
        addr_phase(a);
        bus_start();
        send_byte({4'b1010, cs, 1'b1}, ack);
        check(ack, tag, "read select ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = model[8'(base + 8'(i))];
            e.tag = tag;
            exp_q.push_back(e);
            recv_byte(i != n - 1);
        end
        bus_stop();
        ptr = 8'(base + 8'(n));
    endtask

    // Current address read of one byte (R7)
    task automatic cur_read();
        bit ack;
        exp_t e;
        bus_start();
        send_byte({4'b1010, cs, 1'b1}, ack);
        check(ack, "R7", "current read select ack", ack, 1);
        e.v = model[ptr];
        e.tag = "R7";
        exp_q.push_back(e);
        recv_byte(1'b0);
        bus_stop();
        ptr = ptr + 8'd1;
    endtask

    // Write of n bytes d0, d0+1, ... with page wrap; optional busy poll after
    task automatic wr(input logic [15:0] a, input int n, input logic [7:0] d0,
                      input string tag);
        bit ack;
        logic [7:0] pa;
        addr_phase(a);
        for (int i = 0; i < n; i++) begin
            send_byte(8'(d0 + 8'(i)), ack);
            check(ack == !lock, tag, "data byte ack", ack, !lock);
            pa = (a[7:0] & ~8'((1 << PAGE_W) - 1)) | (8'(a[7:0] + 8'(i)) & 8'((1 << PAGE_W) - 1));
            if (!lock) model[pa] = 8'(d0 + 8'(i));
        end
        bus_stop();
        if (!lock) begin
            bus_start();
            send_byte({4'b1010, cs, 1'b0}, ack);
            check(!ack, "R6", "select ack during write cycle", ack, 0);
            bus_stop();
            tick(WR_CYCLES);
        end
    endtask

    // Scoreboard monitor: compare each received byte with the oldest expectation
    initial begin
        forever begin
            exp_t e;
            logic [7:0] g;
            wait (got_q.size() > 0);
            e = exp_q.pop_front();
            g = got_q.pop_front();
            check(g == e.v, e.tag, "read byte", g, e.v);
        end
    end

    // R9 watcher: SDA drive must not move while SCL is high
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (pull !== prev) && scl) r9_viol++;
            prev = pull;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(pull == 1'b0, "R9", "SDA released after reset", pull, 0);

        // R10: erased contents, also exercises random read (R8)
        rd_expect(16'h0010, 1, "R10");
        cur_read();

        // R3 with R6 poll: single byte write
        wr(16'h0021, 1, 8'h5A, "R3");
        rd_expect(16'h0021, 1, "R3");

        // R4: five bytes from 0x45 wrap inside the 8-byte page; high byte ignored (R2)
        wr(16'h0345, 5, 8'h11, "R4");
        rd_expect(16'h1240, 8, "R4");

        // R7: current address reads follow a single-byte random read
        rd_expect(16'h0045, 1, "R8");
        cur_read();
        cur_read();

        // R8: sequential read runs past the page end
        rd_expect(16'h0046, 3, "R8");

        // R1: wrong chip bits and wrong type nibble are not acknowledged
        bus_start();
        send_byte({4'b1010, ~cs, 1'b0}, ack);
        check(!ack, "R1", "chip mismatch ack", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, cs, 1'b1}, ack);
        check(!ack, "R1", "type mismatch ack", ack, 0);
        bus_stop();
        check(pull == 1'b0, "R1", "SDA released after mismatch", pull, 0);
        rd_expect(16'h0021, 1, "R1");

        // R5: locked write acks select/address, refuses data, changes nothing
        lock = 1'b1;
        wr(16'h0021, 2, 8'h77, "R5");
        lock = 1'b0;
        rd_expect(16'h0021, 2, "R5");

        // R11: stop in the middle of a byte discards the latched data
        addr_phase(16'h0060);
        send_byte(8'hA1, ack);
        check(ack, "R11", "data ack before abort", ack, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        rd_expect(16'h0060, 1, "R11");

        tick(20);
        check(exp_q.size() == 0, "R8", "all expected bytes observed", exp_q.size(), 0);
        check(r9_viol == 0, "R9", "SDA changes while SCL high", r9_viol, 0);
        check(pull == 1'b0, "R9", "SDA released when idle", pull, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule